// File: doc/BRIEF.md
# Daisy-Chained Two-Source Vectored Interrupt Controller

This block is the interrupt section of a peripheral device that shares an 8-bit processor bus with other peripherals. It has two local interrupt sources: an expiry pulse from an on-chip timer, which sits outside this block, and an external interrupt pin. Each source sets a request latch of its own. A bus write to the device's control port loads a two-bit code. The code lets the external source through, lets the timer source through, or blocks both.

Several such devices are connected in a priority chain. A device may interrupt only while its priority input is high. While it holds an enabled pending request, it pulls its priority output low, and this blocks every device further down the chain. The device that holds priority drives the active-low shared request line. When the processor acknowledges, that device returns a 16-bit vector address for one cycle and clears the latch of the source it serviced. The external vector is always the timer vector plus 0x0080.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset the control code is 00 and both request latches are empty. As a result, `int_req_n` is 1, `pri_out` equals `pri_in`, `vec_valid` is 0 and `vec_out` is 0.
- R2: A clocked write with `bus_wr` high to address `PORT_BASE`+2 (default 6) loads `bus_data[1:0]` into the control code. A write to any other address leaves the code unchanged.
- R3: With code 00 or 10, latched requests raise no interrupt: `int_req_n` stays 1 and `pri_out` equals `pri_in`.
- R4: With code 01, only a latched external request is enabled. A latched timer request raises no interrupt.
- R5: With code 11, only a latched timer request is enabled. A latched external request raises no interrupt.
- R6: A request latch holds its request, whether or not it is enabled, until that source is serviced. Enabling the source later raises the interrupt.
- R7: While `pri_in` is 0, `int_req_n` is 1 and `pri_out` is 0, and an acknowledge produces no vector and clears no latch.
- R8: While `pri_in` is 1, `pri_out` is 0 exactly when an enabled request is pending, and `int_req_n` is 0 exactly then.
- R9: An acknowledge in a cycle where `pri_in` is 1 and an enabled request is pending has three effects in the next cycle. `vec_valid` is 1 for one cycle. `vec_out` is `TIMER_VEC` (default 0x0020) for the timer or `TIMER_VEC`+0x0080 (default 0x00A0) for the external source. The serviced latch is clear. If both sources were pending and enabled, the timer is served first.
- R10: An acknowledge with no enabled pending request produces no vector and leaves both latches unchanged.
- R11: The external latch is set by a 0-to-1 transition of `ext_irq`. A level held high after service does not set it again. The timer latch is set by a one-cycle `timer_expire` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_addr | input | 8 | Bus port address |
| bus_data | input | 8 | Bus write data |
| ext_irq | input | 1 | External interrupt pin, rising edge sets a request |
| timer_expire | input | 1 | One-cycle timer expiry pulse |
| pri_in | input | 1 | Priority from the device above in the chain |
| pri_out | output | 1 | Priority passed to the device below |
| int_req_n | output | 1 | Active-low interrupt request |
| ack | input | 1 | Interrupt acknowledge pulse |
| vec_valid | output | 1 | Vector address is valid this cycle |
| vec_out | output | 16 | Vector address, zero when not valid |

## Verification
The assertions assume that `ack` is a single-cycle pulse. They also assume that no new external edge arrives in the same cycle as the acknowledge that services the external latch, so a vector is never followed directly by another one. The stimulus meets both assumptions. It separates every acknowledge from the next by idle cycles, and it raises `ext_irq` only after a reset, well before any acknowledge. Each sweep point starts from a fresh reset, so the latches and the code always begin from the R1 state.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;

   typedef enum logic [1:0] {
      CTL_OFF_A = 2'b00,
      CTL_EXT   = 2'b01,
      CTL_OFF_B = 2'b10,
      CTL_TMR   = 2'b11
   } ctl_code_e;

   localparam int SRC_TMR   = 0;
   localparam int SRC_EXT   = 1;
   localparam int NUM_SRC   = 2;
   localparam int EXT_DELTA = 'h80;

   // returns {ext_enable, timer_enable}
   function automatic logic [1:0] src_enables(input logic [1:0] code);
      logic [1:0] en;
      en[SRC_TMR] = (code == CTL_TMR);
      en[SRC_EXT] = (code == CTL_EXT);
      return en;
   endfunction

endpackage

// File: rtl/irq_ctl_port.sv
module irq_ctl_port #(
   parameter int ADDR_W    = 8,
   parameter int DATA_W    = 8,
   parameter int PORT_BASE = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   output logic [1:0]        ctl_code
);
   localparam logic [ADDR_W-1:0] CTL_ADDR = ADDR_W'(PORT_BASE + 2);

   logic hit;
   assign hit = bus_wr && (bus_addr == CTL_ADDR);

   always_ff @(posedge clk) begin
      if (!rst_n)   ctl_code <= irq_chain_pkg::CTL_OFF_A;
      else if (hit) ctl_code <= bus_data[1:0];
   end
endmodule

// File: rtl/irq_req_latch.sv
module irq_req_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q
);
   // a new request arriving with a service clear wins
   always_ff @(posedge clk) begin
      if (!rst_n)     q <= 1'b0;
      else if (set_i) q <= 1'b1;
      else if (clr_i) q <= 1'b0;
   end
endmodule

// File: rtl/irq_chain_arb.sv
module irq_chain_arb #(
   parameter int          VEC_W     = 16,
   parameter int unsigned TIMER_VEC = 'h20
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [irq_chain_pkg::NUM_SRC-1:0]  lat,
   input  logic [irq_chain_pkg::NUM_SRC-1:0]  en,
   input  logic                               pri_in,
   input  logic                               ack,
   output logic                               pri_out,
   output logic                               int_req_n,
   output logic [irq_chain_pkg::NUM_SRC-1:0]  clr,
   output logic                               vec_valid,
   output logic [VEC_W-1:0]                   vec_out
);
   import irq_chain_pkg::*;

   logic [NUM_SRC-1:0] pend;
   logic [VEC_W-1:0]   src_vec [NUM_SRC];
   logic               any_pend;
   logic               grant;

   genvar g;
   generate
      for (g = 0; g < NUM_SRC; g++) begin : g_vec
         assign src_vec[g] = VEC_W'(TIMER_VEC + g * EXT_DELTA);
      end
   endgenerate

   assign pend      = lat & en;
   assign any_pend  = |pend;
   assign pri_out   = pri_in & ~any_pend;
   assign int_req_n = ~(pri_in & any_pend);
   assign grant     = ack & pri_in & any_pend;

   // fixed order: timer ahead of external
   assign clr[SRC_TMR] = grant & pend[SRC_TMR];
   assign clr[SRC_EXT] = grant & ~pend[SRC_TMR] & pend[SRC_EXT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_valid <= 1'b0;
         vec_out   <= '0;
      end else if (grant) begin
         vec_valid <= 1'b1;
         vec_out   <= clr[SRC_TMR] ? src_vec[SRC_TMR] : src_vec[SRC_EXT];
      end else begin
         vec_valid <= 1'b0;
         vec_out   <= '0;
      end
   end
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl #(
   parameter int          ADDR_W    = 8,
   parameter int          DATA_W    = 8,
   parameter int          VEC_W     = 16,
   parameter int          PORT_BASE = 4,
   parameter int unsigned TIMER_VEC = 'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              ext_irq,
   input  logic              timer_expire,
   input  logic              pri_in,
   output logic              pri_out,
   output logic              int_req_n,
   input  logic              ack,
   output logic              vec_valid,
   output logic [VEC_W-1:0]  vec_out
);
   import irq_chain_pkg::*;

   generate
      if (PORT_BASE % 4 != 0) begin : g_bad_base
         $error("PORT_BASE must be a multiple of four");
      end
      if (PORT_BASE + 3 >= (1 << ADDR_W)) begin : g_bad_span
         $error("port group does not fit ADDR_W");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must hold the two-bit code");
      end
      if (VEC_W > 30 || TIMER_VEC + EXT_DELTA >= (1 << VEC_W)) begin : g_bad_vec
         $error("vectors do not fit VEC_W");
      end
   endgenerate

   logic [1:0]         ctl_code;
   logic [NUM_SRC-1:0] lat, set_req, clr_req, en;
   logic               ext_q;

   irq_ctl_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_BASE(PORT_BASE)) u_port (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_data(bus_data), .ctl_code(ctl_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ext_q <= 1'b0;
      else        ext_q <= ext_irq;
   end

   assign set_req[SRC_TMR] = timer_expire;
   assign set_req[SRC_EXT] = ext_irq & ~ext_q;
   assign en               = src_enables(ctl_code);

   genvar s;
   generate
      for (s = 0; s < NUM_SRC; s++) begin : g_lat
         irq_req_latch u_lat (
            .clk(clk), .rst_n(rst_n), .set_i(set_req[s]), .clr_i(clr_req[s]), .q(lat[s])
         );
      end
   endgenerate

   irq_chain_arb #(.VEC_W(VEC_W), .TIMER_VEC(TIMER_VEC)) u_arb (
      .clk(clk), .rst_n(rst_n), .lat(lat), .en(en), .pri_in(pri_in), .ack(ack),
      .pri_out(pri_out), .int_req_n(int_req_n), .clr(clr_req),
      .vec_valid(vec_valid), .vec_out(vec_out)
   );
endmodule

// File: rtl/irq_chain_ctrl_chk.sv
module irq_chain_ctrl_chk #(
   parameter int          VEC_W     = 16,
   parameter int unsigned TIMER_VEC = 'h20
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pri_in,
   input logic             ack,
   input logic             pri_out,
   input logic             int_req_n,
   input logic             vec_valid,
   input logic [VEC_W-1:0] vec_out,
   input logic [1:0]       ctl_code
);
   localparam logic [VEC_W-1:0] TV = VEC_W'(TIMER_VEC);
   localparam logic [VEC_W-1:0] EV = VEC_W'(TIMER_VEC + 'h80);

   a_r7_no_req_without_pri: assert property (@(posedge clk) disable iff (!rst_n)
      !pri_in |-> (int_req_n && !pri_out));

   a_r8_req_blocks_chain: assert property (@(posedge clk) disable iff (!rst_n)
      !int_req_n |-> !pri_out);

   a_r3_disabled_codes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_code[0] == 1'b0) |-> int_req_n);

   a_r9_vec_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> ($past(ack) && $past(pri_in) && !$past(int_req_n)));

   a_r9_vec_value: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (vec_out == TV || vec_out == EV));

   a_r9_vec_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |=> !vec_valid);

   a_r1_idle_vec_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |-> (vec_out == '0));
endmodule

bind irq_chain_ctrl irq_chain_ctrl_chk #(.VEC_W(VEC_W), .TIMER_VEC(TIMER_VEC)) u_chk (
   .clk(clk), .rst_n(rst_n), .pri_in(pri_in), .ack(ack), .pri_out(pri_out),
   .int_req_n(int_req_n), .vec_valid(vec_valid), .vec_out(vec_out), .ctl_code(ctl_code)
);

// File: tb/irq_chain_ctrl_bench.sv
`timescale 1ns/1ps
module irq_chain_ctrl_bench;
   localparam logic [15:0] TV = 16'h0020;
   localparam logic [15:0] EV = TV + 16'h0080;
   localparam logic [7:0]  CTL = 8'd6;

   logic clk = 0, rst_n = 0, bus_wr = 0, ext_irq = 0, timer_expire = 0, pri_in = 0, ack = 0;
   logic [7:0] bus_addr = 0, bus_data = 0;
   logic pri_out, int_req_n, vec_valid;
   logic [15:0] vec_out;
   int errors = 0, checks = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_chain_ctrl u_irq_chain_ctrl (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_data(bus_data),
      .ext_irq(ext_irq), .timer_expire(timer_expire), .pri_in(pri_in), .pri_out(pri_out),
      .int_req_n(int_req_n), .ack(ack), .vec_valid(vec_valid), .vec_out(vec_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0; ext_irq = 0; pri_in = 0; ack = 0;
      cyc(2); rst_n = 1; #1;
   endtask

   task automatic wr(input logic [7:0] a, input logic [1:0] code);
      @(negedge clk); bus_wr = 1; bus_addr = a; bus_data = {6'd0, code};
      @(negedge clk); bus_wr = 0; #1;
   endtask

   task automatic tmr_pulse();
      @(negedge clk); timer_expire = 1;
      @(negedge clk); timer_expire = 0; #1;
   endtask

   task automatic ext_rise();
      @(negedge clk); ext_irq = 1;
      @(negedge clk); #1;
   endtask

   initial begin
      do_reset();
      pri_in = 1; #1;
      chk("R1 int_req_n", int_req_n, 1);
      chk("R1 pri_out", pri_out, 1);
      chk("R1 vec_valid", vec_valid, 0);
      chk("R1 vec_out", vec_out, 0);

      // R2: writes off the control address leave the code unchanged
      tmr_pulse();
      wr(CTL - 1, 2'b11); chk("R2 addr 5 ignored", int_req_n, 1);
      wr(CTL + 1, 2'b11); chk("R2 addr 7 ignored", int_req_n, 1);
      wr(CTL - 2, 2'b11); chk("R2 addr 4 ignored", int_req_n, 1);
      wr(CTL, 2'b11);     chk("R2 addr 6 loads", int_req_n, 0);

      // sweep: code x timer latched x external latched x priority
      for (int code = 0; code < 4; code++)
         for (int t = 0; t < 2; t++)
            for (int e = 0; e < 2; e++)
               for (int p = 0; p < 2; p++) begin
                  logic ent, ene, pend, svc_t, svc_e;
                  ent = (code == 3); ene = (code == 1);
                  pend = (t && ent) || (e && ene);
                  svc_t = p && t && ent;
                  svc_e = p && !svc_t && e && ene;
                  do_reset();
                  if (t) tmr_pulse();
                  if (e) ext_rise();
                  wr(CTL, code[1:0]);
                  @(negedge clk); pri_in = p[0]; #1;
                  chk(code[0] ? "R8 int_req_n" : "R3 int_req_n", int_req_n, !(pend && p));
                  chk(p ? "R8 pri_out" : "R7 pri_out", pri_out, p && !pend);
                  if (code == 1) chk("R4 only ext", int_req_n, !(p && e));
                  if (code == 3) chk("R5 only timer", int_req_n, !(p && t));
                  @(negedge clk); ack = 1;
                  @(negedge clk); ack = 0; #1;
                  chk((pend && p) ? "R9 vec_valid" : "R10 vec_valid", vec_valid, pend && p);
                  chk("R9 vec_out", vec_out, svc_t ? TV : (svc_e ? EV : 16'h0));
                  @(negedge clk); #1;
                  chk("R9 one cycle", vec_valid, 0);
                  // R6: remaining latches still held, shown by enabling each source
                  pri_in = 1;
                  wr(CTL, 2'b11);
                  chk("R6 timer latch", int_req_n, !(t && !svc_t));
                  wr(CTL, 2'b01);
                  chk("R6 ext latch", int_req_n, !(e && !svc_e));
               end

      // R11: held external level does not set the latch again after service
      do_reset();
      pri_in = 1;
      wr(CTL, 2'b01);
      ext_rise();
      chk("R11 edge sets", int_req_n, 0);
      @(negedge clk); ack = 1;
      @(negedge clk); ack = 0; #1;
      chk("R11 ext vector", vec_out, EV);
      cyc(3); #1;
      chk("R11 level no reset", int_req_n, 1);
      @(negedge clk); ext_irq = 0;
      cyc(1); ext_irq = 1; cyc(1); #1;
      chk("R11 new edge sets", int_req_n, 0);
      wr(CTL, 2'b11);
      chk("R11 timer idle", int_req_n, 1);
      tmr_pulse();
      chk("R11 timer pulse sets", int_req_n, 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule